// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block decides when, and into which sleep state, a processor-driven power-down happens. Software first preconditions it through a small configuration word: a deep-sleep select, a mode-request field and an interrupt enable for the invalid-transition flag. Writing that word never changes the power state. The sequencer acts only when the processor raises one of its sleep triggers: wait-for-interrupt, wait-for-event or sleep-on-exit.

On a trigger, the block either enters the shallow sleep state tied to the current active mode, or it checks a request for deep sleep against a table of allowed starting active modes. An allowed deep entry locks the power-control and clock-system registers until wake-up. A disallowed one sets a sticky flag and aborts the deep entry. In that case the block either falls back to shallow sleep or stays active and raises an interrupt, depending on the flag's enable. Wake-up returns the block to the active state. The wake sources are an external reset or NMI request, a debugger halt or reset request, and any pending interrupt whose enable is set.

Top module: `lpm_entry_seq`

## Requirements
- R1: After reset `pwr_mode` is 0 (active), and `regs_locked`, `inv_flag` and `irq_out` are all 0. The configuration is cleared to deep=0, request=0 and enable=0.
- R2: A configuration write never changes `pwr_mode`. While active with no trigger, the mode stays 0. A write takes effect at the clock edge that samples it, and a trigger on that same edge still uses the old configuration.
- R3: In active mode, a trigger with deep select 0 moves `pwr_mode` to 1 (shallow sleep) at the edge that samples the trigger.
- R4: A trigger with deep select 1 and a nonzero request field also enters shallow sleep (1). Only a request field of 0 asks for deep sleep.
- R5: A deep request from an allowed active mode (`act_mode` 0 or 2 by default) moves `pwr_mode` to 2 and sets `regs_locked` at the same edge.
- R6: A deep request from a disallowed active mode (1 or 3) sets `inv_flag` and never enters mode 2. With the flag enable at 0, the block enters shallow sleep (1). With the enable at 1, it stays active (0).
- R7: `irq_out` equals `inv_flag` AND the registered enable. The flag stays set until a clear request while unlocked. If a set and a clear arrive on the same edge, the set wins.
- R8: In either sleep state, `wake_rst_nmi`, `wake_dbg`, or any bit set in both `irq_pend` and `irq_en` returns `pwr_mode` to 0 and clears `regs_locked` at the next edge. A pending interrupt without its enable does not wake the block.
- R9: While `regs_locked` is 1, configuration writes and flag clears are ignored. This is seen after wake-up: the old configuration still governs the next trigger, and the flag is still set.
- R10: Sleep triggers are ignored while the block is asleep. `pwr_mode` holds until a wake source appears.
- R11: The wait-for-interrupt, wait-for-event and sleep-on-exit triggers have identical effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_deep | input | 1 | Deep-sleep select written by `cfg_wr` |
| cfg_req | input | REQ_W | Mode-request field written by `cfg_wr` (0 = deep request) |
| cfg_ie | input | 1 | Invalid-transition interrupt enable written by `cfg_wr` |
| cfg_inv_clr | input | 1 | Clear request for the invalid-transition flag |
| trig_wfi | input | 1 | Wait-for-interrupt sleep trigger |
| trig_wfe | input | 1 | Wait-for-event sleep trigger |
| trig_soe | input | 1 | Sleep-on-exit trigger |
| act_mode | input | ACT_W | Current active mode code |
| wake_rst_nmi | input | 1 | External reset or NMI wake request |
| wake_dbg | input | 1 | Debugger halt or reset wake request |
| irq_pend | input | N_IRQ | Pending interrupt and latched I/O events |
| irq_en | input | N_IRQ | Enables for `irq_pend` |
| pwr_mode | output | 2 | 0 active, 1 shallow sleep, 2 deep sleep |
| regs_locked | output | 1 | Lock on power-control and clock-system registers |
| inv_flag | output | 1 | Sticky invalid-transition flag |
| irq_out | output | 1 | Invalid-transition interrupt request |

## Verification
Every result is registered once. A trigger, wake source, configuration write or flag clear driven before edge k is visible on `pwr_mode`, `regs_locked` and `inv_flag` just after edge k. `irq_out` follows `inv_flag` and the enable in that same cycle. The bench drives inputs a quarter period after each rising edge and advances a behavioural model on that edge, using only the pre-edge model state. It compares all four outputs every cycle, a quarter period after the edge, so no check depends on process order.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'd0,
    PM_SHALLOW = 2'd1,
    PM_DEEP    = 2'd2
  } pmode_e;
endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg #(
  parameter int REQ_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             locked,
  input  logic             deep_d,
  input  logic [REQ_W-1:0] req_d,
  input  logic             ie_d,
  output logic             deep_q,
  output logic [REQ_W-1:0] req_q,
  output logic             ie_q
);
  logic upd_en;

  assign upd_en = wr_en & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deep_q <= 1'b0;
      req_q  <= '0;
      ie_q   <= 1'b0;
    end else if (upd_en) begin
      deep_q <= deep_d;
      req_q  <= req_d;
      ie_q   <= ie_d;
    end
  end

  // R9: a write arriving while locked leaves the configuration untouched
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en) |=> ($stable(deep_q) && $stable(req_q) && $stable(ie_q)));
endmodule

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
  parameter int N_IRQ = 8
) (
  input  logic             rst_nmi,
  input  logic             dbg,
  input  logic [N_IRQ-1:0] pend,
  input  logic [N_IRQ-1:0] en,
  output logic             wake
);
  logic [N_IRQ-1:0] armed;

  assign armed = pend & en;
  assign wake  = rst_nmi | dbg | (|armed);
endmodule

// File: rtl/lpm_trans_check.sv
module lpm_trans_check #(
  parameter int                    ACT_W      = 2,
  parameter logic [(1<<ACT_W)-1:0] VALID_MASK = 4'b0101
) (
  input  logic [ACT_W-1:0] act_mode,
  input  logic             deep_sel,
  input  logic             req_zero,
  output logic             deep_req,
  output logic             tr_valid
);
  localparam int N_ACT = 1 << ACT_W;

  logic [N_ACT-1:0] hit;

  for (genvar gi = 0; gi < N_ACT; gi++) begin : g_row
    if (VALID_MASK[gi]) begin : g_ok
      assign hit[gi] = (act_mode == ACT_W'(gi));
    end else begin : g_bad
      assign hit[gi] = 1'b0;
    end
  end

  assign deep_req = deep_sel & req_zero;
  assign tr_valid = |hit;
endmodule

// File: rtl/lpm_entry_seq.sv
module lpm_entry_seq
  import lpm_pkg::*;
#(
  parameter int                    ACT_W      = 2,
  parameter int                    REQ_W      = 2,
  parameter int                    N_IRQ      = 8,
  parameter logic [(1<<ACT_W)-1:0] VALID_MASK = 4'b0101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_deep,
  input  logic [REQ_W-1:0] cfg_req,
  input  logic             cfg_ie,
  input  logic             cfg_inv_clr,
  input  logic             trig_wfi,
  input  logic             trig_wfe,
  input  logic             trig_soe,
  input  logic [ACT_W-1:0] act_mode,
  input  logic             wake_rst_nmi,
  input  logic             wake_dbg,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  output logic [1:0]       pwr_mode,
  output logic             regs_locked,
  output logic             inv_flag,
  output logic             irq_out
);
  pmode_e           mode_q, mode_d;
  logic             lock_q, lock_d;
  logic             flag_q, flag_d;
  logic             deep_q, ie_q;
  logic [REQ_W-1:0] req_q;
  logic             deep_req, tr_valid, wake, trig_any, inv_set;
  logic             st_en, flag_en;

  lpm_cfg_reg #(.REQ_W(REQ_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .locked(lock_q),
    .deep_d(cfg_deep), .req_d(cfg_req), .ie_d(cfg_ie),
    .deep_q(deep_q), .req_q(req_q), .ie_q(ie_q)
  );

  lpm_trans_check #(.ACT_W(ACT_W), .VALID_MASK(VALID_MASK)) u_chk (
    .act_mode(act_mode), .deep_sel(deep_q), .req_zero(req_q == '0),
    .deep_req(deep_req), .tr_valid(tr_valid)
  );

  lpm_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .rst_nmi(wake_rst_nmi), .dbg(wake_dbg), .pend(irq_pend), .en(irq_en),
    .wake(wake)
  );

  assign trig_any = trig_wfi | trig_wfe | trig_soe;

  // next-state decision
  always_comb begin
    mode_d  = mode_q;
    lock_d  = lock_q;
    inv_set = 1'b0;
    case (mode_q)
      PM_ACTIVE: begin
        if (trig_any) begin
          if (!deep_req) begin
            mode_d = PM_SHALLOW;
          end else if (tr_valid) begin
            mode_d = PM_DEEP;
            lock_d = 1'b1;
          end else begin
            inv_set = 1'b1;
            if (!ie_q) mode_d = PM_SHALLOW;
          end
        end
      end
      default: begin
        if (wake) begin
          mode_d = PM_ACTIVE;
          lock_d = 1'b0;
        end
      end
    endcase
  end

  always_comb begin
    flag_d = flag_q;
    if (inv_set)                     flag_d = 1'b1;
    else if (cfg_inv_clr && !lock_q) flag_d = 1'b0;
  end

  assign st_en   = (mode_q == PM_ACTIVE) ? trig_any : wake;
  assign flag_en = inv_set | cfg_inv_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_ACTIVE;
      lock_q <= 1'b0;
    end else if (st_en) begin
      mode_q <= mode_d;
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign pwr_mode    = mode_q;
  assign regs_locked = lock_q;
  assign inv_flag    = flag_q;
  assign irq_out     = flag_q & ie_q;

  // R2: without a trigger the active state persists, whatever is written
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd0 && !trig_any) |=> (pwr_mode == 2'd0));
  // R5: the lock exists only during deep sleep
  p_lock_in_deep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    regs_locked |-> (pwr_mode == 2'd2));
  // R6: a newly raised invalid flag never coincides with deep sleep
  p_invalid_no_deep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_flag) |-> (pwr_mode != 2'd2));
  // R7: the interrupt requires the flag
  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> inv_flag);
  // R8: a wake source in sleep returns to active and unlocks
  p_wake_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'd0 && wake) |=> (pwr_mode == 2'd0 && !regs_locked));
  // R10: asleep without wake, the mode holds regardless of triggers
  p_sleep_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'd0 && !wake) |=> $stable(pwr_mode));
endmodule

// File: tb/tb_lpm_entry_seq.sv
module tb_lpm_entry_seq;
  localparam int N_IRQ = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr, cfg_deep, cfg_ie, cfg_inv_clr;
  logic [1:0] cfg_req;
  logic trig_wfi, trig_wfe, trig_soe;
  logic [1:0] act_mode;
  logic wake_rst_nmi, wake_dbg;
  logic [N_IRQ-1:0] irq_pend, irq_en;
  logic [1:0] pwr_mode;
  logic regs_locked, inv_flag, irq_out;

  int n_chk = 0;
  int n_fail = 0;
  string cur = "R1";

  // behavioural reference state
  int m_mode;
  bit m_lock, m_flag, m_deep, m_ie;
  int m_req;

  always #10 clk = ~clk;

  lpm_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_deep(cfg_deep),
    .cfg_req(cfg_req), .cfg_ie(cfg_ie), .cfg_inv_clr(cfg_inv_clr),
    .trig_wfi(trig_wfi), .trig_wfe(trig_wfe), .trig_soe(trig_soe),
    .act_mode(act_mode), .wake_rst_nmi(wake_rst_nmi), .wake_dbg(wake_dbg),
    .irq_pend(irq_pend), .irq_en(irq_en), .pwr_mode(pwr_mode),
    .regs_locked(regs_locked), .inv_flag(inv_flag), .irq_out(irq_out)
  );

  task automatic model_step();
    bit trig, wake, ok, set, n_lock;
    int n_mode;
    if (!rst_n) begin
      m_mode = 0; m_lock = 0; m_flag = 0; m_deep = 0; m_req = 0; m_ie = 0;
      return;
    end
    trig = trig_wfi || trig_wfe || trig_soe;
    wake = wake_rst_nmi || wake_dbg || ((irq_pend & irq_en) != 0);
    ok   = (act_mode == 0) || (act_mode == 2);
    set = 0; n_mode = m_mode; n_lock = m_lock;
    if (m_mode == 0) begin
      if (trig) begin
        if (!(m_deep && m_req == 0)) n_mode = 1;
        else if (ok) begin n_mode = 2; n_lock = 1; end
        else begin set = 1; if (!m_ie) n_mode = 1; end
      end
    end else if (wake) begin
      n_mode = 0; n_lock = 0;
    end
    if (set) m_flag = 1;
    else if (cfg_inv_clr && !m_lock) m_flag = 0;
    if (cfg_wr && !m_lock) begin
      m_deep = cfg_deep; m_req = cfg_req; m_ie = cfg_ie;
    end
    m_mode = n_mode; m_lock = n_lock;
  endtask

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #5;
    chk("pwr_mode", pwr_mode, m_mode);
    chk("regs_locked", regs_locked, m_lock);
    chk("inv_flag", inv_flag, m_flag);
    chk("irq_out", irq_out, m_flag && m_ie);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic trig(int which);
    if (which == 0) trig_wfi = 1; else if (which == 1) trig_wfe = 1; else trig_soe = 1;
    tick();
    trig_wfi = 0; trig_wfe = 0; trig_soe = 0;
  endtask

  task automatic wr(bit d, int r, bit ie);
    cfg_wr = 1; cfg_deep = d; cfg_req = 2'(r); cfg_ie = ie;
    tick();
    cfg_wr = 0;
  endtask

  task automatic clr();
    cfg_inv_clr = 1; tick(); cfg_inv_clr = 0;
  endtask

  task automatic wake_irq();
    irq_pend = 8'h10; irq_en = 8'h10; tick(); irq_pend = 0; irq_en = 0;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired in %s", cur);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_deep = 0; cfg_req = 0; cfg_ie = 0; cfg_inv_clr = 0;
    trig_wfi = 0; trig_wfe = 0; trig_soe = 0; act_mode = 0;
    wake_rst_nmi = 0; wake_dbg = 0; irq_pend = 0; irq_en = 0;
    // R1: reset values
    cur = "R1"; idle(3);
    rst_n = 1; idle(2);
    // R2: writes alone never move the mode
    cur = "R2"; wr(0, 3, 0); idle(2); wr(1, 0, 0); idle(2); wr(0, 0, 0);
    // R3: shallow entry, then R10 ignored triggers, R8 masked pend
    cur = "R3"; trig(0); idle(1);
    cur = "R10"; trig(1); trig(2); idle(1);
    cur = "R8"; irq_pend = 8'hFF; irq_en = 8'h00; idle(2); irq_pend = 0;
    wake_irq(); idle(1);
    // R11: other triggers, other wake sources
    cur = "R11"; trig(1); idle(1);
    cur = "R8"; wake_dbg = 1; tick(); wake_dbg = 0;
    cur = "R11"; trig(2); idle(1);
    cur = "R8"; wake_rst_nmi = 1; tick(); wake_rst_nmi = 0;
    // R4: deep select with nonzero request gives shallow
    cur = "R4"; wr(1, 2, 0); trig(0); idle(1); wake_irq();
    // R2: write and trigger on one edge, old config governs
    cur = "R2"; cfg_wr = 1; cfg_deep = 1; cfg_req = 0; cfg_ie = 0; trig_wfi = 1;
    tick(); cfg_wr = 0; trig_wfi = 0; wake_irq();
    // R5: valid deep entries from modes 0 and 2
    cur = "R5"; act_mode = 0; trig(0); idle(2);
    // R9: write while locked is dropped
    cur = "R9"; wr(0, 1, 1); wake_irq(); trig(1); idle(1); wake_irq();
    cur = "R5"; act_mode = 2; trig(2); idle(1); wake_dbg = 1; tick(); wake_dbg = 0;
    // R6: invalid from mode 1 with enable 0 -> shallow
    cur = "R6"; act_mode = 1; trig(0); idle(1); wake_irq();
    // R7: enable set raises irq, clear drops it
    cur = "R7"; wr(1, 0, 1); idle(1); clr(); idle(1);
    // R6: invalid from mode 3 with enable 1 -> stays active
    cur = "R6"; act_mode = 3; trig(1); idle(2);
    // R7: set and clear on one edge, set wins
    cur = "R7"; clr(); act_mode = 1; cfg_inv_clr = 1; trig_soe = 1; tick();
    cfg_inv_clr = 0; trig_soe = 0; idle(1);
    // R9: clear while locked ignored
    cur = "R9"; act_mode = 0; trig(0); clr(); idle(1); wake_irq(); idle(1);
    clr(); idle(1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule